// File: doc/BRIEF.md
# Switchable-Rate Periodic Service Interrupt

This block raises a periodic interrupt request that tells the processor to service the front panel. A free-running binary prescaler divides the system clock by 2^`PRESCALE_W`, which is 8192 by default. At a clock near 15.17 MHz, that gives one request about every 540 µs. A second binary stage of `SLOW_W` bits (divide by 32 by default) follows the prescaler. While the display-blank input is high, the slow stage must reach its own terminal count before a request fires. The rate then drops to one request per 2^(`PRESCALE_W`+`SLOW_W`) clocks, which is 262144 by default, and this lowers the load on the processor.

The request is a level signal. It is set on each qualifying terminal count and stays high until a one-cycle acknowledge clears it. Terminal counts that arrive while a request is pending are merged into that request and not counted. A change of the blank input is sampled only at a prescaler terminal count, so every period is a whole number of prescaler periods.

Top module: `panel_tick_irq`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the prescaler, the slow stage and the request, so `irq_req` is low in the cycle after reset.
- R2: With `blank_mode` low, `irq_req` rises after exactly 2^`PRESCALE_W` rising clock edges counted from the first edge with `rst` low. Later requests follow every 2^`PRESCALE_W` clocks.
- R3: With `blank_mode` held high, requests rise exactly 2^(`PRESCALE_W`+`SLOW_W`) clocks apart.
- R4: Once set, `irq_req` stays high until a clock edge at which `irq_ack` is high.
- R5: An edge with `irq_ack` high and no qualifying terminal count drives `irq_req` low in the next cycle.
- R6: When a qualifying terminal count and `irq_ack` occur at the same edge, the new request wins and `irq_req` stays high.
- R7: `blank_mode` is sampled only at a prescaler terminal count. If it is low at that edge, a request fires there. If it is high, the slow stage advances, and while the mode is low the slow stage is held at zero.
- R8: A terminal count that occurs while a request is pending leaves `irq_req` high and is not queued. A single acknowledge clears the request, and no further request appears until the next qualifying terminal count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| blank_mode | input | 1 | High selects the reduced rate (display blanked) |
| irq_ack | input | 1 | One-cycle acknowledge that clears the request |
| irq_req | output | 1 | Level interrupt request |

## Verification
The assertions check the following on every cycle: the request is cleared by reset, a pending request is held until acknowledged, and it is dropped after an acknowledge. They also check that a new request can only rise at a prescaler terminal count, that an ignored blank-mode count never sets it, and that terminal counts are exactly 2^`PRESCALE_W` clocks apart. The bench scenarios are needed to show the following: the absolute latency to the first request, the long blank-mode interval between requests, and that a request wins when it meets an acknowledge at the same edge. They also show that leaving blank mode produces a request at the very next prescaler terminal count, and that merged terminal counts leave nothing queued after one acknowledge.

// File: rtl/panel_tick_irq.sv
module panel_tick_irq #(
  parameter int PRESCALE_W = 13,
  parameter int SLOW_W     = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic blank_mode,
  input  logic irq_ack,
  output logic irq_req
);

  logic [PRESCALE_W-1:0] pre_cnt;
  logic [SLOW_W-1:0]     slow_cnt;
  logic                  pre_tc;
  logic                  slow_full;
  logic                  fire;

  assign pre_tc    = &pre_cnt;
  assign slow_full = &slow_cnt;
  assign fire      = pre_tc && (!blank_mode || slow_full);

  always_ff @(posedge clk) begin
    if (rst) pre_cnt <= '0;
    else     pre_cnt <= pre_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)
      slow_cnt <= '0;
    else if (pre_tc)
      slow_cnt <= blank_mode ? slow_cnt + 1'b1 : '0;
  end

  always_ff @(posedge clk) begin
    if (rst)          irq_req <= 1'b0;
    else if (fire)    irq_req <= 1'b1;
    else if (irq_ack) irq_req <= 1'b0;
  end

endmodule

module panel_tick_irq_chk #(
  parameter int PRESCALE_W = 13,
  parameter int SLOW_W     = 5
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  blank_mode,
  input logic                  irq_ack,
  input logic                  irq_req,
  input logic [PRESCALE_W-1:0] pre_cnt,
  input logic [SLOW_W-1:0]     slow_cnt
);

  localparam int GAP_W = PRESCALE_W + 1;
  localparam logic [GAP_W-1:0] PERIOD = GAP_W'(1) << PRESCALE_W;

  logic tc_seen;
  logic [GAP_W-1:0] gap;
  logic tc_now;
  assign tc_now = (pre_cnt == {PRESCALE_W{1'b1}});

  always_ff @(posedge clk) begin
    if (rst) begin
      gap     <= '0;
      tc_seen <= 1'b0;
    end else if (tc_now) begin
      gap     <= GAP_W'(1);
      tc_seen <= 1'b1;
    end else begin
      gap <= gap + 1'b1;
    end
  end

  a_r1_reset_clear: assert property (@(posedge clk) rst |=> !irq_req);

  a_r4_hold_pending: assert property (@(posedge clk) disable iff (rst)
    (irq_req && !irq_ack) |=> irq_req);

  a_r5_ack_clears: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && !tc_now) |=> !irq_req);

  a_r2_rise_at_tc: assert property (@(posedge clk) disable iff (rst)
    (!irq_req && !tc_now) |=> !irq_req);

  a_r3_blank_skip: assert property (@(posedge clk) disable iff (rst)
    (tc_now && blank_mode && !(&slow_cnt) && (!irq_req || irq_ack)) |=> !irq_req);

  a_r7_normal_fires: assert property (@(posedge clk) disable iff (rst)
    (tc_now && !blank_mode) |=> irq_req);

  a_r2_tc_spacing: assert property (@(posedge clk) disable iff (rst)
    (tc_now && tc_seen) |-> (gap == PERIOD));

endmodule

bind panel_tick_irq panel_tick_irq_chk #(.PRESCALE_W(PRESCALE_W), .SLOW_W(SLOW_W)) u_chk (
  .clk(clk), .rst(rst), .blank_mode(blank_mode), .irq_ack(irq_ack),
  .irq_req(irq_req), .pre_cnt(pre_cnt), .slow_cnt(slow_cnt)
);

// File: tb/panel_tick_irq_tb.sv
module panel_tick_irq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 8;
  localparam int SW = 5;
  localparam int PMAX = (1 << PW) - 1;
  localparam int SMAX = (1 << SW) - 1;
  localparam int FULL_PERIOD = 8192;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic blank = 1'b0;
  logic ack = 1'b0;
  logic irq;
  logic irq_full;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int m_pre = 0;
  int m_slow = 0;
  bit m_irq = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  panel_tick_irq #(.PRESCALE_W(PW), .SLOW_W(SW)) u_dut (
    .clk(clk), .rst(rst), .blank_mode(blank), .irq_ack(ack), .irq_req(irq)
  );

  panel_tick_irq u_dut_full (
    .clk(clk), .rst(rst), .blank_mode(1'b0), .irq_ack(1'b0), .irq_req(irq_full)
  );

  function automatic bit model_fire(int pre, int slow, bit b);
    return (pre == PMAX) && (!b || slow == SMAX);
  endfunction

  task automatic check(bit act, bit exp, string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual=%0b expected=%0b", req, cyc, act, exp);
    end
  endtask

  task automatic step();
    bit f;
    @(posedge clk);
    if (rst) begin
      m_pre = 0; m_slow = 0; m_irq = 0; cyc = 0;
    end else begin
      cyc++;
      f = model_fire(m_pre, m_slow, blank);
      if (f) m_irq = 1;
      else if (ack) m_irq = 0;
      if (m_pre == PMAX) m_slow = blank ? ((m_slow + 1) & SMAX) : 0;
      m_pre = (m_pre + 1) & PMAX;
    end
    @(negedge clk);
    check(irq, m_irq, "R4/R5 model");
    if (!rst && cyc == FULL_PERIOD - 1) check(irq_full, 1'b0, "R2 full-size before period");
    if (!rst && cyc == FULL_PERIOD)     check(irq_full, 1'b1, "R2 full-size at period");
  endtask

  task automatic pulse_ack();
    ack = 1'b1; step(); ack = 1'b0;
  endtask

  task automatic run_to_tc();
    while (m_pre != PMAX) step();
  endtask

  initial begin
    int last_rise;
    int gap;
    bit prev;
    void'($urandom(32'd1234));
    @(negedge clk);
    step(); step();
    check(irq, 1'b0, "R1 reset state");
    rst = 1'b0;

    // R2 first request latency
    repeat (PMAX) step();
    check(irq, 1'b0, "R2 one edge before period");
    step();
    check(irq, 1'b1, "R2 request at period");

    // R8 merge: pass another TC without ack
    repeat (PMAX + 1) step();
    check(irq, 1'b1, "R8 stays high across TC");
    pulse_ack();
    check(irq, 1'b0, "R5 ack clears");
    repeat (10) step();
    check(irq, 1'b0, "R8 nothing queued");

    // R6 ack at terminal count
    run_to_tc();
    ack = 1'b1; step(); ack = 1'b0;
    check(irq, 1'b1, "R6 fire beats ack");
    pulse_ack();
    check(irq, 1'b0, "R5 ack clears again");

    // R3 blank-mode spacing between two rises
    blank = 1'b1;
    last_rise = -1;
    gap = 0;
    prev = irq;
    while (gap == 0) begin
      step();
      if (irq && !prev) begin
        if (last_rise >= 0) gap = cyc - last_rise;
        last_rise = cyc;
        pulse_ack();
      end
      prev = irq;
    end
    checks++;
    if (gap != (1 << (PW + SW))) begin
      errors++;
      $display("FAIL R3 blank interval: actual=%0d expected=%0d", gap, 1 << (PW + SW));
    end

    // R7 leave blank mid window: fire at next prescaler TC
    repeat (3) begin run_to_tc(); step(); end
    check(irq, 1'b0, "R7 still quiet in blank");
    blank = 1'b0;
    run_to_tc();
    step();
    check(irq, 1'b1, "R7 fires at next TC after leaving blank");
    pulse_ack();

    // random phase
    for (int i = 0; i < 20000; i++) begin
      if (($urandom % 500) == 0) blank = ~blank;
      ack = (irq && ($urandom % 8) == 0) ? 1'b1 : (($urandom % 64) == 0);
      step();
    end
    ack = 1'b0;

    // R1 reset mid-run
    rst = 1'b1; step(); rst = 1'b0;
    check(irq, 1'b0, "R1 reset clears request");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule